// File: doc/BRIEF.md
# Status Register Read Port

This block answers processor reads of a single 8-bit status register on an ISA-style peripheral bus. It watches the active-low read strobe, an active-low select, the address-enable line and a two-bit register address. All of them pass through a two-stage synchronizer into the core clock domain. When the strobe falls while the select, address-enable and address match, the block builds the return byte. It then steers an external bidirectional bus transceiver towards the bus and drives the data pins.

The byte combines four status bits, which controlling logic stores through a simple write port, with the current levels of the device's DMA-request and interrupt-request lines. Output enable and transceiver direction follow a strict order. The transceiver turns outbound one clock before the pins are enabled. When the strobe ends, the pins are released one clock before the transceiver turns back.

Top module: `status_rd_port`

## Requirements
- R1: A read starts when the synchronized strobe `bus_rd_n` falls while `bus_sel_n` is low, `bus_aen` is low and `bus_addr` equals 2'b01 (bit 1 low, bit 0 high).
- R2: A strobe fall with `bus_sel_n` high, `bus_aen` high or `bus_addr` different from 2'b01 is ignored: `xcvr_dir` and `data_oe` stay low for the whole strobe.
- R3: The driven byte has the stored status in bits 3:0, the `irq_lvl` level in bit 4 and the `drq_lvl` level in bit 5, and bits 7:6 are zero.
- R4: The status bits returned are the most recent value written with `sts_wr_en`. A write in the clock cycle in which the byte is captured (the cycle when `xcvr_dir` is high and `data_oe` is still low) is included in that byte.
- R5: `data_oe` is never high while `xcvr_dir` is low. `xcvr_dir` rises at least one clock before `data_oe`.
- R6: After the strobe returns high, `data_oe` falls first and `xcvr_dir` falls one clock later.
- R7: `data_oe` rises on the fourth rising clock edge after the strobe falls, well inside a budget of about 23 core cycles.
- R8: While `data_oe` is low, `data_out` is all zeros.
- R9: While `data_oe` stays high, `data_out` does not change, even if the status is written during the read. Such a write is returned by the next read.
- R10: After reset, `xcvr_dir`, `data_oe` and `data_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd_n | input | 1 | Bus read strobe, active low, asynchronous |
| bus_sel_n | input | 1 | Device select, active low, asynchronous |
| bus_aen | input | 1 | Address enable (high during DMA cycles), asynchronous |
| bus_addr | input | 2 | Low register address bits, asynchronous |
| drq_lvl | input | 1 | Current level of the device DMA-request output |
| irq_lvl | input | 1 | Current level of the device interrupt-request output |
| sts_wr_en | input | 1 | Store a new status value this cycle |
| sts_wr_val | input | 4 | Status value to store |
| xcvr_dir | output | 1 | Transceiver direction, 1 = device to bus |
| data_oe | output | 1 | Output enable for the data pins |
| data_out | output | 8 | Byte presented on the data pins |

## Verification
A status write from the controlling logic can land in the same cycle as the byte capture that follows a matching strobe. The bench provokes this by watching for the cycle in which the transceiver has turned but the pins are not yet enabled, and it pulses the write exactly then. The scoreboard expects the new value in that read. It also places a write in the middle of a driven read, where the scoreboard expects the old byte for the current read and the new value for the next one.

// File: rtl/status_rd_pkg.sv
package status_rd_pkg;

    localparam int STS_BITS  = 4;
    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_TURN  = 2'd1,
        RP_DRIVE = 2'd2,
        RP_REL   = 2'd3
    } rp_state_e;

endpackage

// File: rtl/status_rd_sync.sv
module status_rd_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/status_rd_decode.sv
module status_rd_decode #(
    parameter logic [1:0] MATCH_ADDR = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_n_i,
    input  logic       sel_n_i,
    input  logic       aen_i,
    input  logic [1:0] addr_i,
    output logic       start_o
);

    typedef struct packed {
        logic rd_prev;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d         = dec_q;
        dec_d.rd_prev = rd_n_i;
        start_o = dec_q.rd_prev && !rd_n_i && !sel_n_i && !aen_i
                  && (addr_i == MATCH_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{rd_prev: 1'b1};
        else        dec_q <= dec_d;
    end

    // R1
    start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!dec_q.rd_prev && !start_o));

endmodule

// File: rtl/status_rd_seq.sv
module status_rd_seq #(
    parameter int STS_W  = status_rd_pkg::STS_BITS,
    parameter int DATA_W = status_rd_pkg::BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_n_i,
    input  logic              drq_i,
    input  logic              irq_i,
    input  logic              wr_en_i,
    input  logic [STS_W-1:0]  wr_val_i,
    output logic              dir_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] data_o
);
    import status_rd_pkg::*;

    localparam int IRQ_POS = STS_W;
    localparam int DRQ_POS = STS_W + 1;

    typedef struct packed {
        rp_state_e         st;
        logic [STS_W-1:0]  sts;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [STS_W-1:0]  sts_now;
    logic [DATA_W-1:0] packed_byte;

    always_comb begin
        sts_now                = wr_en_i ? wr_val_i : seq_q.sts;
        packed_byte            = '0;
        packed_byte[STS_W-1:0] = sts_now;
        packed_byte[IRQ_POS]   = irq_i;
        packed_byte[DRQ_POS]   = drq_i;

        seq_d     = seq_q;
        seq_d.sts = sts_now;
        case (seq_q.st)
            RP_IDLE: begin
                seq_d.data = '0;
                if (start_i) seq_d.st = RP_TURN;
            end
            RP_TURN: begin
                seq_d.data = packed_byte;
                seq_d.st   = RP_DRIVE;
            end
            RP_DRIVE: begin
                if (rd_n_i) begin
                    seq_d.data = '0;
                    seq_d.st   = RP_REL;
                end
            end
            default: begin
                seq_d.data = '0;
                seq_d.st   = RP_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: RP_IDLE, sts: '0, data: '0};
        else        seq_q <= seq_d;
    end

    assign dir_o  = (seq_q.st != RP_IDLE);
    assign oe_o   = (seq_q.st == RP_DRIVE);
    assign data_o = seq_q.data;

    // R5
    oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> dir_o);
    // R5
    dir_leads_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(dir_o));
    // R6
    oe_leads_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_o) |-> !$past(oe_o));
    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && $past(oe_o)) |-> $stable(data_o));
    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (data_o == '0));
    // R3
    top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> (data_o[DATA_W-1:DRQ_POS+1] == '0));

endmodule

// File: rtl/status_rd_port.sv
module status_rd_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rd_n,
    input  logic       bus_sel_n,
    input  logic       bus_aen,
    input  logic [1:0] bus_addr,
    input  logic       drq_lvl,
    input  logic       irq_lvl,
    input  logic       sts_wr_en,
    input  logic [3:0] sts_wr_val,
    output logic       xcvr_dir,
    output logic       data_oe,
    output logic [7:0] data_out
);
    import status_rd_pkg::*;

    localparam int SYNC_W      = 5;
    localparam int SYNC_STAGES = 2;
    // bit order: addr[1:0], aen, sel_n, rd_n ; strobes idle high
    localparam logic [SYNC_W-1:0] SYNC_RST = 5'b00011;

    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              start;

    assign raw_bus = {bus_addr, bus_aen, bus_sel_n, bus_rd_n};

    status_rd_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (syn_bus)
    );

    status_rd_decode #(
        .MATCH_ADDR (2'b01)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_n_i  (syn_bus[0]),
        .sel_n_i (syn_bus[1]),
        .aen_i   (syn_bus[2]),
        .addr_i  (syn_bus[4:3]),
        .start_o (start)
    );

    status_rd_seq #(
        .STS_W  (STS_BITS),
        .DATA_W (BYTE_BITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .rd_n_i   (syn_bus[0]),
        .drq_i    (drq_lvl),
        .irq_i    (irq_lvl),
        .wr_en_i  (sts_wr_en),
        .wr_val_i (sts_wr_val),
        .dir_o    (xcvr_dir),
        .oe_o     (data_oe),
        .data_o   (data_out)
    );

endmodule

// File: tb/status_rd_port_bench.sv
`timescale 1ns/1ps
module status_rd_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd_n = 1'b1, bus_sel_n = 1'b1, bus_aen = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic       drq_lvl = 1'b0, irq_lvl = 1'b0;
    logic       sts_wr_en = 1'b0;
    logic [3:0] sts_wr_val = 4'h0;
    logic       xcvr_dir, data_oe;
    logic [7:0] data_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    logic [3:0] sts_model = 4'h0;
    logic       prev_oe = 1'b0, prev_dir = 1'b0;
    logic [7:0] prev_data = 8'h00;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    status_rd_port u_status_rd_port (
        .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_sel_n(bus_sel_n),
        .bus_aen(bus_aen), .bus_addr(bus_addr), .drq_lvl(drq_lvl),
        .irq_lvl(irq_lvl), .sts_wr_en(sts_wr_en), .sts_wr_val(sts_wr_val),
        .xcvr_dir(xcvr_dir), .data_oe(data_oe), .data_out(data_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pack_exp(input logic [3:0] s);
        return {2'b00, drq_lvl, irq_lvl, s};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (data_oe && !prev_oe) begin
                if (exp_q.size() == 0) check(1'b0, "R1 unexpected read", data_out, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(data_out == e, "R3/R4 byte", data_out, e);
                end
            end
            if (data_oe && !xcvr_dir) check(1'b0, "R5 oe without dir", data_oe, 0);
            if (data_oe && !prev_oe && !prev_dir) check(1'b0, "R5 dir not ahead", prev_dir, 1);
            if (prev_dir && !xcvr_dir && prev_oe) check(1'b0, "R6 dir fell with oe", prev_oe, 0);
            if (data_oe && prev_oe && data_out != prev_data)
                check(1'b0, "R9 data moved", data_out, prev_data);
            if (!data_oe && data_out != 8'h00) check(1'b0, "R8 data not quiet", data_out, 0);
            prev_oe   <= data_oe;
            prev_dir  <= xcvr_dir;
            prev_data <= data_out;
        end
    end

    task automatic write_sts(input logic [3:0] v);
        @(negedge clk);
        sts_wr_en = 1'b1; sts_wr_val = v;
        @(negedge clk);
        sts_wr_en = 1'b0;
        sts_model = v;
    endtask

    // mode 0: plain; 1: write in capture cycle; 2: write while driving
    task automatic do_read(input int mode, input logic [3:0] wv);
        int n;
        logic [3:0] s;
        s = (mode == 1) ? wv : sts_model;
        @(negedge clk);
        bus_sel_n = 1'b0; bus_aen = 1'b0; bus_addr = 2'b01;
        repeat (3) @(negedge clk);
        exp_q.push_back(pack_exp(s));
        bus_rd_n = 1'b0;
        n = 0;
        while (!data_oe && n < 30) begin
            @(negedge clk);
            n++;
            if (mode == 1 && xcvr_dir && !data_oe && !sts_wr_en && n < 5) begin
                sts_wr_en = 1'b1; sts_wr_val = wv;
            end else begin
                sts_wr_en = 1'b0;
            end
        end
        sts_wr_en = 1'b0;
        if (mode == 1) sts_model = wv;
        check(n == 4, "R7 latency", n, 4);
        if (mode == 2) begin
            sts_wr_en = 1'b1; sts_wr_val = wv;
            @(negedge clk);
            sts_wr_en = 1'b0;
            sts_model = wv;
        end
        repeat (4) @(negedge clk);
        check(data_oe && xcvr_dir, "R9 held while strobe low", data_oe, 1);
        bus_rd_n = 1'b1;
        n = 0;
        while (xcvr_dir && n < 30) begin
            @(negedge clk);
            n++;
        end
        check(!xcvr_dir && !data_oe, "R6 released", xcvr_dir, 0);
        bus_sel_n = 1'b1; bus_addr = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    task automatic bad_read(input logic sel_n, input logic aen, input logic [1:0] a);
        bit quiet;
        quiet = 1'b1;
        @(negedge clk);
        bus_sel_n = sel_n; bus_aen = aen; bus_addr = a;
        repeat (3) @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (xcvr_dir || data_oe) quiet = 1'b0;
        end
        bus_rd_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (xcvr_dir || data_oe) quiet = 1'b0;
        end
        check(quiet, "R2 ignored decode", {xcvr_dir, data_oe}, 0);
        bus_sel_n = 1'b1; bus_aen = 1'b0; bus_addr = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!xcvr_dir && !data_oe && data_out == 8'h00, "R10 reset state",
              {xcvr_dir, data_oe, data_out}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R3 basic reads with varied live lines
        write_sts(4'hA);
        do_read(0, 4'h0);
        drq_lvl = 1'b1; irq_lvl = 1'b0;
        do_read(0, 4'h0);
        drq_lvl = 1'b0; irq_lvl = 1'b1;
        write_sts(4'h5);
        do_read(0, 4'h0);
        drq_lvl = 1'b1; irq_lvl = 1'b1;
        write_sts(4'hF);
        do_read(0, 4'h0);

        // R2 each disqualifier alone
        bad_read(1'b1, 1'b0, 2'b01);
        bad_read(1'b0, 1'b1, 2'b01);
        bad_read(1'b0, 1'b0, 2'b11);
        bad_read(1'b0, 1'b0, 2'b00);
        bad_read(1'b0, 1'b0, 2'b10);

        // R4 latest of two writes
        write_sts(4'h3);
        write_sts(4'hC);
        drq_lvl = 1'b0; irq_lvl = 1'b0;
        do_read(0, 4'h0);

        // R4 write in the capture cycle
        do_read(1, 4'h6);
        do_read(0, 4'h0);

        // R9 write during drive returned by the next read
        do_read(2, 4'h9);
        do_read(0, 4'h0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R1 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule